// File: doc/BRIEF.md
# Global Configuration and Status Register Bank

This block is the global register bank of a two-channel motor-driver controller. A simple register bus (address, write data, write strobe, read strobe, read data) reaches four locations: a configuration word that can lock itself, a status word of sticky event flags that clear when read, a write-only test-select field and a read-only word that reports an enable-pin level and a version number. The configuration bits leave the block as decoded control lines. The status flags are fed by the error conditions of the two drivers and by a charge-pump undervoltage signal.

The configuration path is built around a two-state lock machine. In state `CFG_OPEN` a write to the configuration address updates the word. A write whose lock bit (bit 10) is 1 takes the transition `lock_write` into `CFG_LOCKED`. In `CFG_LOCKED` every configuration write is dropped, and the only way back to `CFG_OPEN` is the `reset` transition. Reset puts the machine in `CFG_OPEN`. The status flags follow a set-dominant rule: a present condition always sets its flag, and a read clears a flag only if the condition has gone away.

Read data is combinational. While `rd_en` is high, `rdata` shows the addressed word as it stands before the clock edge. A clear caused by that read takes effect at the edge. While `rd_en` is low, `rdata` is zero.

Top module: `gcs_regbank`

## Requirements
- R1: Address 0x00 holds the configuration word. Bits 3, 7, 8, 9 and 10 are stored from a write. All other bits read as zero. The reset value is zero.
- R2: `pp_int_oe` equals configuration bit 3. It is high when the bit is 1, and low (pulse and interrupt outputs tristated) when the bit is 0.
- R3: `test_mode` follows configuration bit 7. `dir_inv1` follows bit 8. `dir_inv2` follows bit 9.
- R4: A configuration write with bit 10 set locks the word. Every later write to 0x00 is ignored until reset. Reset clears the lock.
- R5: Status (address 0x01) bit 0 is 1 after reset and stays 1 until the first read of 0x01.
- R6: Status bits 1 and 2 latch `drv1_err` and `drv2_err` respectively. A read of 0x01 clears such a bit only if its condition is low in the read cycle.
- R7: Status bit 3 latches `cp_uv` under the same clear rule. `drv_disable` is high exactly while bit 3 is set.
- R8: A read of 0x01 returns the flags as they were before the read. A condition present in the read cycle leaves its flag set, so no event is lost.
- R9: Address 0x03 is a write-only 4-bit test-select field taken from `wdata[3:0]`. It drives `test_sel`, resets to 0 and reads as zero.
- R10: Reading address 0x04 returns `enable_pin` in bit 7 and the version 0x01 in bits 31:24, with all other bits zero. Writes to 0x04 are ignored.
- R11: Reading any other address returns zero. Writes to other addresses, and to 0x01, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears status on 0x01) |
| rdata | output | 32 | Read data, zero when not reading |
| drv1_err | input | 1 | Driver 1 shutdown condition |
| drv2_err | input | 1 | Driver 2 shutdown condition |
| cp_uv | input | 1 | Charge-pump undervoltage condition |
| enable_pin | input | 1 | Level of the external enable pin |
| pp_int_oe | output | 1 | Output enable for pulse and interrupt pins |
| test_mode | output | 1 | Test-mode flag |
| dir_inv1 | output | 1 | Invert motor 1 direction |
| dir_inv2 | output | 1 | Invert motor 2 direction |
| test_sel | output | 4 | Test-select field |
| drv_disable | output | 1 | Driver disable from undervoltage flag |

## Verification
The assertions check several rules on every cycle:
- the configuration word stays frozen under writes once locked, and the lock never releases without reset;
- a driver error or undervoltage condition always leaves its flag set one cycle later;
- a set flag survives any cycle without a status read;
- the reset flag falls only after a read;
- the output enable rises only through an unlocked write;
- unmapped reads return zero.

Only the bench's scenarios can show the exact values of the words read back. They also cover:
- the masking of reserved bits and the version/pin word;
- a clearing read that coincides with a new event;
- the sequence in which a held condition survives reads and is then released;
- recovery from lock through reset.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
    localparam int CFG_W   = 11;
    localparam int STAT_W  = 4;
    localparam int TSEL_W  = 4;

    localparam int ADR_CFG  = 'h00;
    localparam int ADR_STAT = 'h01;
    localparam int ADR_TSEL = 'h03;
    localparam int ADR_INFO = 'h04;

    localparam int BIT_OE     = 3;
    localparam int BIT_TEST   = 7;
    localparam int BIT_INV1   = 8;
    localparam int BIT_INV2   = 9;
    localparam int BIT_LOCK   = 10;
    localparam int INFO_PIN   = 7;
    localparam int INFO_VER_LSB = 24;

    localparam logic [CFG_W-1:0] CFG_MASK =
        CFG_W'((1 << BIT_OE) | (1 << BIT_TEST) | (1 << BIT_INV1) |
               (1 << BIT_INV2) | (1 << BIT_LOCK));

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/gcs_cfg_reg.sv
module gcs_cfg_reg
    import gcs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              locked
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(CFG_MASK);

    lock_state_e state_q, state_d;
    logic [CFG_W-1:0] cfg_d;
    logic [DATA_W-1:0] masked;

    assign masked = wdata & WMASK;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_OPEN;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    // next state and data
    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            CFG_OPEN: begin
                if (wr_cfg) begin
                    cfg_d = masked[CFG_W-1:0];
                    if (wdata[BIT_LOCK]) state_d = CFG_LOCKED;
                end
            end
            CFG_LOCKED: begin
                state_d = CFG_LOCKED;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CFG_OPEN:   locked = 1'b0;
            CFG_LOCKED: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/gcs_status_reg.sv
module gcs_status_reg
    import gcs_pkg::*;
#(
    parameter int NCOND = STAT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_rd,
    input  logic [NCOND-1:0]  cond,
    output logic [STAT_W-1:0] stat_q
);
    // bit 0: reset indicator, cleared by the first status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stat_q[0] <= 1'b1;
        else if (clr_rd) stat_q[0] <= 1'b0;
    end

    // condition flags: set dominates, clear only when the condition is gone
    for (genvar i = 0; i < NCOND; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       stat_q[i+1] <= 1'b0;
            else if (cond[i]) stat_q[i+1] <= 1'b1;
            else if (clr_rd)  stat_q[i+1] <= 1'b0;
        end
    end
endmodule

// File: rtl/gcs_rd_mux.sv
module gcs_rd_mux
    import gcs_pkg::*;
#(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 32,
    parameter logic [7:0]  VERSION = 8'h01
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic [CFG_W-1:0]  cfg_q,
    input  logic [STAT_W-1:0] stat_q,
    input  logic              enable_pin,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] info;

    always_comb begin
        info = '0;
        info[INFO_PIN] = enable_pin;
        info[INFO_VER_LSB +: 8] = VERSION;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(ADR_CFG):  rdata = DATA_W'(cfg_q);
                ADDR_W'(ADR_STAT): rdata = DATA_W'(stat_q);
                ADDR_W'(ADR_INFO): rdata = info;
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gcs_regbank.sv
module gcs_regbank
    import gcs_pkg::*;
#(
    parameter int         ADDR_W  = 8,
    parameter int         DATA_W  = 32,
    parameter logic [7:0] VERSION = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              drv1_err,
    input  logic              drv2_err,
    input  logic              cp_uv,
    input  logic              enable_pin,
    output logic              pp_int_oe,
    output logic              test_mode,
    output logic              dir_inv1,
    output logic              dir_inv2,
    output logic [TSEL_W-1:0] test_sel,
    output logic              drv_disable
);
    logic [CFG_W-1:0]  cfg_q;
    logic [STAT_W-1:0] stat_q;
    logic              locked;
    logic              wr_cfg, wr_tsel, rd_stat;

    assign wr_cfg  = wr_en && (addr == ADDR_W'(ADR_CFG));
    assign wr_tsel = wr_en && (addr == ADDR_W'(ADR_TSEL));
    assign rd_stat = rd_en && (addr == ADDR_W'(ADR_STAT));

    gcs_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (wr_cfg),
        .wdata  (wdata),
        .cfg_q  (cfg_q),
        .locked (locked)
    );

    gcs_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_rd (rd_stat),
        .cond   ({cp_uv, drv2_err, drv1_err}),
        .stat_q (stat_q)
    );

    gcs_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_rd (
        .addr       (addr),
        .rd_en      (rd_en),
        .cfg_q      (cfg_q),
        .stat_q     (stat_q),
        .enable_pin (enable_pin),
        .rdata      (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       test_sel <= '0;
        else if (wr_tsel) test_sel <= wdata[TSEL_W-1:0];
    end

    assign pp_int_oe   = cfg_q[BIT_OE];
    assign test_mode   = cfg_q[BIT_TEST];
    assign dir_inv1    = cfg_q[BIT_INV1];
    assign dir_inv2    = cfg_q[BIT_INV2];
    assign drv_disable = stat_q[STAT_W-1];
endmodule

// File: rtl/gcs_regbank_chk.sv
module gcs_regbank_chk
    import gcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic              drv1_err,
    input logic              drv2_err,
    input logic              cp_uv,
    input logic              pp_int_oe,
    input logic              drv_disable,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [STAT_W-1:0] stat_q,
    input logic              locked
);
    logic hit_cfg, hit_stat, mapped;
    assign hit_cfg  = addr == ADDR_W'(ADR_CFG);
    assign hit_stat = addr == ADDR_W'(ADR_STAT);
    assign mapped   = hit_cfg || hit_stat || addr == ADDR_W'(ADR_INFO);

    assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && hit_cfg) |=> $stable(cfg_q));
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    assert_oe_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pp_int_oe) |-> $past(wr_en && hit_cfg && !locked));
    assert_rstflag_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[0]) |-> $past(rd_en && hit_stat));
    assert_drv1_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv1_err |=> stat_q[1]);
    assert_drv2_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv2_err |=> stat_q[2]);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !(rd_en && hit_stat)) |=> stat_q[1]);
    assert_uv_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_uv |=> drv_disable);
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> rdata == '0);
endmodule

bind gcs_regbank gcs_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rdata       (rdata),
    .drv1_err    (drv1_err),
    .drv2_err    (drv2_err),
    .cp_uv       (cp_uv),
    .pp_int_oe   (pp_int_oe),
    .drv_disable (drv_disable),
    .cfg_q       (cfg_q),
    .stat_q      (stat_q),
    .locked      (locked)
);

// File: tb/gcs_regbank_tb.sv
`timescale 1ns/1ps
module gcs_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] rdata;
    logic        drv1_err = 1'b0, drv2_err = 1'b0, cp_uv = 1'b0, enable_pin = 1'b1;
    logic        pp_int_oe, test_mode, dir_inv1, dir_inv2, drv_disable;
    logic [3:0]  test_sel;
    int n_chk = 0, n_fail = 0;
    logic [31:0] d;

    always #4 clk = ~clk;   // 125 MHz

    gcs_regbank u_dut (.*);

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h01, 32'h0,        32'h1,        8'd5},  // R5 reset flag
        '{1'b0, 8'h01, 32'h0,        32'h0,        8'd5},  // R5 cleared
        '{1'b0, 8'h00, 32'h0,        32'h0,        8'd1},  // R1 reset value
        '{1'b1, 8'h00, 32'h3FF,      32'h0,        8'd1},
        '{1'b0, 8'h00, 32'h0,        32'h388,      8'd1},  // R1 masking
        '{1'b1, 8'h03, 32'h4,        32'h0,        8'd9},
        '{1'b0, 8'h03, 32'h0,        32'h0,        8'd9},  // R9 write-only
        '{1'b0, 8'h04, 32'h0,        32'h01000080, 8'd10}, // R10
        '{1'b1, 8'h04, 32'hFFFFFFFF, 32'h0,        8'd10},
        '{1'b0, 8'h04, 32'h0,        32'h01000080, 8'd10}, // R10 write ignored
        '{1'b1, 8'h20, 32'hFFFF,     32'h0,        8'd11},
        '{1'b0, 8'h20, 32'h0,        32'h0,        8'd11}, // R11
        '{1'b0, 8'h02, 32'h0,        32'h0,        8'd11}, // R11
        '{1'b1, 8'h01, 32'hF,        32'h0,        8'd11},
        '{1'b0, 8'h01, 32'h0,        32'h0,        8'd11}, // R11 status write ignored
        '{1'b0, 8'h00, 32'h0,        32'h388,      8'd11}  // R11 cfg untouched
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R2 oe at reset", {31'b0, pp_int_oe}, 32'h0);
        chk("R9 test_sel at reset", {28'b0, test_sel}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].a, VECS[i].wd);
            else begin
                rd(VECS[i].a, d);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
            end
        end
        chk("R2 oe on", {31'b0, pp_int_oe}, 32'h1);
        chk("R3 outs", {29'b0, test_mode, dir_inv1, dir_inv2}, 32'h7);
        chk("R9 test_sel", {28'b0, test_sel}, 32'h4);

        // R2 / R3: clear bit 3 and bit 9
        wr(8'h00, 32'h180);
        chk("R2 oe off", {31'b0, pp_int_oe}, 32'h0);
        chk("R3 outs", {29'b0, test_mode, dir_inv1, dir_inv2}, 32'h6);

        // R4: lock
        wr(8'h00, 32'h408);
        rd(8'h00, d); chk("R4 locked word", d, 32'h408);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R4 write ignored", d, 32'h408);
        chk("R4 oe kept", {31'b0, pp_int_oe}, 32'h1);
        do_reset();
        rd(8'h00, d); chk("R4 reset unlocks", d, 32'h0);
        wr(8'h00, 32'h8);
        rd(8'h00, d); chk("R4 writable again", d, 32'h8);
        rd(8'h01, d); chk("R5 flag after reset", d, 32'h1);

        // R6: pulsed driver 1 error
        @(negedge clk); drv1_err = 1'b1;
        @(negedge clk); drv1_err = 1'b0;
        rd(8'h01, d); chk("R6 drv1 latched", d, 32'h2);
        rd(8'h01, d); chk("R6 drv1 cleared", d, 32'h0);

        // R6: held driver 2 error survives reads
        @(negedge clk); drv2_err = 1'b1;
        rd(8'h01, d); chk("R6 drv2 set", d, 32'h4);
        rd(8'h01, d); chk("R6 drv2 held", d, 32'h4);
        @(negedge clk); drv2_err = 1'b0;
        rd(8'h01, d); chk("R6 drv2 last", d, 32'h4);
        rd(8'h01, d); chk("R6 drv2 cleared", d, 32'h0);

        // R8: event in the same cycle as the clearing read
        @(negedge clk); addr = 8'h01; rd_en = 1'b1; drv1_err = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; drv1_err = 1'b0;
        chk("R8 read shows old", d, 32'h0);
        rd(8'h01, d); chk("R8 event kept", d, 32'h2);
        rd(8'h01, d); chk("R8 then cleared", d, 32'h0);

        // R7: undervoltage
        @(negedge clk); cp_uv = 1'b1;
        @(negedge clk); cp_uv = 1'b0;
        chk("R7 disable set", {31'b0, drv_disable}, 32'h1);
        rd(8'h01, d); chk("R7 flag", d, 32'h8);
        chk("R7 disable cleared", {31'b0, drv_disable}, 32'h0);

        // R10: pin level low
        enable_pin = 1'b0;
        rd(8'h04, d); chk("R10 pin low", d, 32'h01000000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule